// File: doc/BRIEF.md
# FM Deviation and Rate Controller

This block builds the frequency word that drives a phase accumulator. It holds a 32-bit carrier word and a 16-bit unsigned modulation value. It shifts the modulation value left by a selectable power of two. It then adds the shifted value to the carrier or subtracts it, according to a sign input that is captured along with the value. The sum is registered and presented as `freq_word` on every clock.

The carrier word is captured after a falling edge on the carrier strobe. The modulation value can be captured in two ways. In manual mode it follows a falling edge on the FM strobe. In automatic mode it is captured at a fixed cadence of every 4, 8 or 16 clocks. In automatic mode the block drives an active-low sync pulse so that the source can present new data in time. A simultaneous-update input makes an FM strobe edge also capture the carrier, so that both values take effect in the same cycle.

Top module: `fm_freq_word`

## Requirements
- R1: An asynchronous active-low reset clears `freq_word` to 0, clears the held carrier and modulation values, and sets `fm_sync_n` high.
- R2: `fm_scale` values 0, 1, 2 and 3 shift the captured 16-bit modulation value left by 0, 4, 8 and 12 bits before it is combined with the carrier.
- R3: A captured `fm_sub` of 1 subtracts the shifted value from the carrier, and 0 adds it. `fm_sub` and `fm_scale` are captured on the same edge as `fm_val`.
- R4: The sum wraps modulo 2^32.
- R5: When `rate` is 0, the block sees an FM strobe falling edge when `fm_ld` is sampled high on one clock edge and low on the next. The clock edge after that captures `fm_val`, and the edge after the capture updates `freq_word`. `fm_sync_n` stays high in this mode.
- R6: When `rate` is 1, 2 or 3, `fm_sync_n` is low for exactly one cycle after every clock edge whose count since reset is a multiple of 4, 8 or 16 respectively. It is high otherwise.
- R7: In automatic mode, `fm_val` is captured on the clock edge at which `fm_sync_n` is low, but only if `fm_ld` is low at that edge. If `fm_ld` is high, the capture is skipped.
- R8: A falling edge on `car_ld` captures `carrier_word` one edge later, and `freq_word` reflects it one edge after that.
- R9: An FM strobe falling edge seen while `sim_ld` is high also captures `carrier_word`. When `sim_ld` is low, that edge leaves the held carrier unchanged.
- R10: When carrier and FM strobe edges fall on the same clock edge, both values are captured together and the next `freq_word` reflects both.
- R11: While no value is captured, `freq_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_word | input | 32 | Carrier frequency word offered for capture |
| car_ld | input | 1 | Carrier load strobe, acts on its falling edge |
| fm_ld | input | 1 | FM load strobe (manual mode) / auto-load inhibit when high |
| sim_ld | input | 1 | Makes an FM strobe edge also load the carrier |
| fm_val | input | 16 | Unsigned modulation magnitude |
| fm_sub | input | 1 | Modulation sign: 1 subtract, 0 add |
| fm_scale | input | 2 | Left-shift select: 0, 4, 8 or 12 bits |
| rate | input | 2 | 0 manual; 1, 2, 3 automatic every 4, 8, 16 clocks |
| fm_sync_n | output | 1 | Active-low one-cycle pulse marking an automatic capture |
| freq_word | output | 32 | Registered frequency word for the accumulator |

## Verification
The assertions check some properties on every cycle. The sync pulse never lasts more than one cycle, and it stays high in manual mode. The held carrier changes only after a detected strobe. An inhibited automatic slot leaves the modulation value untouched. `freq_word` stays steady whenever nothing was captured. Other behaviour can only be shown by the bench's scenarios against its reference model. These are the shift amounts, the sign handling and wrap-around, the two-edge latency, the pulse cadence for each rate, and the merging of simultaneous and coincident loads.

// File: rtl/fm_freq_word.sv
module fm_freq_word #(
  parameter int CW = 32,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] carrier_word,
  input  logic          car_ld,
  input  logic          fm_ld,
  input  logic          sim_ld,
  input  logic [FW-1:0] fm_val,
  input  logic          fm_sub,
  input  logic [1:0]    fm_scale,
  input  logic [1:0]    rate,
  output logic          fm_sync_n,
  output logic [CW-1:0] freq_word
);
  localparam int SHW = 4;

  logic          fm_ld_q, car_ld_q;
  logic          fm_take, car_take;
  logic [3:0]    cnt, mask;
  logic [FW-1:0] fm_q;
  logic          sub_q;
  logic [1:0]    sc_q;
  logic [CW-1:0] car_q, scaled;

  wire fm_fall  = fm_ld_q & ~fm_ld & (rate == 2'b00);
  wire car_fall = car_ld_q & ~car_ld;
  wire fm_cap   = fm_take | (~fm_sync_n & ~fm_ld);

  always_comb begin
    case (rate)
      2'b01:   mask = 4'd3;
      2'b10:   mask = 4'd7;
      2'b11:   mask = 4'd15;
      default: mask = 4'd0;
    endcase
  end

  assign scaled = CW'(fm_q) << {sc_q, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fm_ld_q   <= 1'b0;
      car_ld_q  <= 1'b0;
      fm_take   <= 1'b0;
      car_take  <= 1'b0;
      cnt       <= '0;
      fm_sync_n <= 1'b1;
      fm_q      <= '0;
      sub_q     <= 1'b0;
      sc_q      <= '0;
      car_q     <= '0;
      freq_word <= '0;
    end else begin
      fm_ld_q   <= fm_ld;
      car_ld_q  <= car_ld;
      fm_take   <= fm_fall;
      car_take  <= car_fall | (fm_fall & sim_ld);
      cnt       <= cnt + 4'd1;
      fm_sync_n <= !((rate != 2'b00) && ((cnt & mask) == mask));
      if (fm_cap) begin
        fm_q  <= fm_val;
        sub_q <= fm_sub;
        sc_q  <= fm_scale;
      end
      if (car_take) car_q <= carrier_word;
      freq_word <= sub_q ? car_q - scaled : car_q + scaled;
    end
  end

  assert_sync_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fm_sync_n |=> fm_sync_n);

  assert_manual_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 2'b00) |=> fm_sync_n);

  assert_car_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !car_take |=> $stable(car_q));

  assert_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fm_sync_n && fm_ld && !fm_take) |=> $stable(fm_q));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!car_take && !fm_cap) |=> ##1 $stable(freq_word));
endmodule

// File: tb/tb_fm_freq_word.sv
`timescale 1ns/1ps
module tb_fm_freq_word;
  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] carrier_word;
  logic car_ld, fm_ld, sim_ld, fm_sub;
  logic [15:0] fm_val;
  logic [1:0] fm_scale, rate;
  logic fm_sync_n;
  logic [31:0] freq_word;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fm_freq_word dut (
    .clk(clk), .rst_n(rst_n), .carrier_word(carrier_word), .car_ld(car_ld),
    .fm_ld(fm_ld), .sim_ld(sim_ld), .fm_val(fm_val), .fm_sub(fm_sub),
    .fm_scale(fm_scale), .rate(rate), .fm_sync_n(fm_sync_n), .freq_word(freq_word)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic        p_fm, p_car, pend_fm, pend_car, m_sync, m_sub;
  logic [15:0] m_fm;
  logic [1:0]  m_sc;
  logic [31:0] m_car, m_word;
  int          n;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_fm = 0; p_car = 0; pend_fm = 0; pend_car = 0; m_sync = 1; m_sub = 0;
      m_fm = 0; m_sc = 0; m_car = 0; m_word = 0; n = 0;
    end else begin
      logic [31:0] sh, nw;
      logic cap_fm, fall_fm;
      int per;
      sh = {16'h0, m_fm} << (4 * m_sc);
      nw = m_sub ? m_car - sh : m_car + sh;
      cap_fm = pend_fm || (!m_sync && !fm_ld);
      if (cap_fm) begin m_fm = fm_val; m_sub = fm_sub; m_sc = fm_scale; end
      if (pend_car) m_car = carrier_word;
      fall_fm = p_fm && !fm_ld && (rate == 0);
      pend_fm = fall_fm;
      pend_car = (p_car && !car_ld) || (fall_fm && sim_ld);
      n++;
      per = (rate == 1) ? 4 : (rate == 2) ? 8 : 16;
      m_sync = !((rate != 0) && (n % per == 0));
      p_fm = fm_ld; p_car = car_ld;
      m_word = nw;
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk("R5 word vs model", freq_word, m_word);
      chk("R6 sync vs model", {31'b0, fm_sync_n}, {31'b0, m_sync});
    end
  end

  task automatic pulse(bit f, bit c);
    @(negedge clk);
    if (f) fm_ld = 0;
    if (c) car_ld = 0;
    @(negedge clk);
    fm_ld = 1; car_ld = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic count_sync(int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!fm_sync_n) lows++;
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lows;
    rst_n = 0; car_ld = 1; fm_ld = 1; sim_ld = 0; rate = 0;
    fm_val = 0; fm_sub = 0; fm_scale = 0; carrier_word = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", freq_word, 32'h0);
    chk("R1 reset sync", {31'b0, fm_sync_n}, 32'h1);
    rst_n = 1;

    carrier_word = 32'h12345678;
    pulse(0, 1);
    chk("R8 carrier load", freq_word, 32'h12345678);

    fm_val = 16'h00AB; fm_scale = 1; fm_sub = 0;
    pulse(1, 0);
    chk("R2 shift by 4", freq_word, 32'h12346128);

    fm_val = 16'hFFFF; fm_scale = 3; fm_sub = 1;
    pulse(1, 0);
    chk("R3 subtract shift 12", freq_word, 32'h02346678);

    fm_val = 16'h0100; fm_scale = 2; fm_sub = 0;
    pulse(1, 0);
    chk("R2 shift by 8", freq_word, 32'h12355678);

    carrier_word = 32'hFFFFF000;
    pulse(0, 1);
    chk("R4 wrap", freq_word, 32'h0000F000);

    sim_ld = 1; carrier_word = 32'h00100000; fm_val = 16'h1; fm_scale = 0;
    pulse(1, 0);
    chk("R9 simultaneous load", freq_word, 32'h00100001);

    sim_ld = 0; carrier_word = 32'h00200000; fm_val = 16'h2;
    pulse(1, 0);
    chk("R9 fm-only load", freq_word, 32'h00100002);

    carrier_word = 32'h00300000; fm_val = 16'h3;
    pulse(1, 1);
    chk("R10 coincident loads", freq_word, 32'h00300003);

    carrier_word = 32'hDEADBEEF; fm_val = 16'h5555; fm_sub = 1;
    repeat (5) @(negedge clk);
    chk("R11 hold", freq_word, 32'h00300003);

    fm_sub = 0; fm_val = 16'h0010;
    rate = 1; fm_ld = 0;
    count_sync(32, lows);
    chk("R6 rate 1 pulses", lows, 32'd8);
    chk("R7 auto capture", freq_word, 32'h00300010);

    rate = 2;
    count_sync(32, lows);
    chk("R6 rate 2 pulses", lows, 32'd4);

    rate = 3;
    count_sync(32, lows);
    chk("R6 rate 3 pulses", lows, 32'd2);

    rate = 1; fm_ld = 1; fm_val = 16'h0777;
    repeat (16) @(negedge clk);
    chk("R7 inhibited auto load", freq_word, 32'h00300010);

    rate = 0;
    count_sync(16, lows);
    chk("R5 manual no sync", lows, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule